// File: doc/BRIEF.md
# Queue-Context Mailbox Command Engine

The engine gives a host a 128-bit register-mapped mailbox for sending queue-context commands to the device. The host writes the mailbox as two 64-bit halves. It writes the upper half first, and then the lower half with the busy flag set. That second write hands the mailbox to the engine. The engine then works on the command code, the direction flag, the queue number and the 64-bit base address already held in the mailbox. It performs the operation against a local context store. After a fixed, parameterised number of cycles it clears busy and writes a 4-bit result code into the control word.

The host polls the lower half until busy drops. A zero result means success and any other value means failure. For a read, the engine returns the 64-bit value in the two base-address fields. Each finished command advances a completion counter. While a command is in flight, the mailbox ignores every host write.

Top module: `mbx_engine`

## Requirements
- R1: After reset, both mailbox halves and the completion counter read zero.
- R2: Field layout. The lower half holds the control word in bits 15:0, the queue number in bits 31:16 and base-low in bits 63:32. The upper half holds base-high in bits 31:0 and a token in bits 63:32. Within the control word, bit 13 is busy, bit 14 is the direction (0 store, 1 fetch), bits 12:9 are the result code and bits 3:0 are the command code. While the engine is idle, a write replaces the selected half. A lower-half write with bit 13 clear starts nothing.
- R3: A command starts only on a lower-half write with bit 13 set while the engine is idle. Busy then reads 1 for exactly LAT clock cycles.
- R4: While busy, writes to either half are ignored. They neither change the mailbox nor start a second command.
- R5: Codes 0 to 3 select one of four context classes. A store to a queue below NQ saves {base-high, base-low} for that class and queue, and completes with result 0.
- R6: A fetch from codes 0 to 3 returns the stored value in {base-high, base-low} with result 0. Each class and queue entry is independent, and an entry never written returns zero.
- R7: Codes 4 and 5 address two table-base registers. Store and fetch work as in R5 and R6, except that the queue number is ignored.
- R8: Code 6 is a fetch-only function-table query. It returns QBASE in bits 37:28, a valid flag in bit 44 and NQ-1 in bits 54:45 of {base-high, base-low}. A store to code 6 completes with result 3 and changes nothing.
- R9: Codes 7 to 15 complete with result 1 in either direction and leave all stored state and base fields unchanged.
- R10: For codes 0 to 3, a queue number of NQ or above completes with result 2, stores nothing and leaves the base fields unchanged.
- R11: The completion counter increases by exactly one per finished command, whatever its result, and holds otherwise.
- R12: On completion, busy clears and the result code is written. Direction, command bits, queue number and token keep the values the host wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for one 64-bit half |
| wr_sel_hi | input | 1 | 1 selects the upper half, 0 the lower half |
| wr_data | input | 64 | Data for the selected half |
| mb_lo | output | 64 | Lower mailbox half (control, queue, base-low) |
| mb_hi | output | 64 | Upper mailbox half (base-high, token) |
| done_cnt | output | CW | Completed-command counter |

## Verification
The bench sweeps every class and queue pair with a store. Each stored value is a distinct arithmetic function of class and queue, so a fetch that returns the wrong entry or a wrong-half swap shows up as a mismatch. It then sends all sixteen command codes in both directions. This separates success, unsupported, read-only and out-of-range results, and checks afterwards that failed commands left stored entries intact. Out-of-range queue numbers just above NQ are tried to find an off-by-one in the bound. Host writes injected mid-command show whether the busy lockout holds. Each command also measures the busy window and compares the counter.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BUSY_BIT = 13;
  localparam int DIR_BIT  = 14;
  localparam int RES_LSB  = 9;

  typedef enum logic [3:0] {
    RES_OK     = 4'd0,
    RES_BADCMD = 4'd1,
    RES_BADQ   = 4'd2,
    RES_RDONLY = 4'd3
  } mbx_res_e;

  typedef enum logic [1:0] {
    KIND_CTX  = 2'd0,
    KIND_TBL  = 2'd1,
    KIND_FUNC = 2'd2,
    KIND_NONE = 2'd3
  } mbx_kind_e;

  // Function-table query word: base, valid flag, count minus one.
  function automatic logic [63:0] func_word(input logic [9:0] base, input logic [10:0] num);
    logic [9:0] nm1;
    nm1 = 10'(num - 11'd1);
    return (64'(base) << 28) | (64'd1 << 44) | (64'(nm1) << 45);
  endfunction
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [3:0]    cmd,
  input  logic          dir_fetch,
  input  logic [15:0]   queue,
  output mbx_kind_e     kind,
  output mbx_res_e      res,
  output logic [QW-1:0] qidx
);
  logic q_ok;
  assign q_ok = (32'(queue) < NQ);
  assign qidx = QW'(queue);

  always_comb begin
    kind = KIND_NONE;
    res  = RES_BADCMD;
    case (cmd)
      4'd0, 4'd1, 4'd2, 4'd3: begin
        kind = KIND_CTX;
        res  = q_ok ? RES_OK : RES_BADQ;
      end
      4'd4, 4'd5: begin
        kind = KIND_TBL;
        res  = RES_OK;
      end
      4'd6: begin
        kind = KIND_FUNC;
        res  = dir_fetch ? RES_OK : RES_RDONLY;
      end
      default: begin
        kind = KIND_NONE;
        res  = RES_BADCMD;
      end
    endcase
  end
endmodule

// File: rtl/mbx_ctx_store.sv
module mbx_ctx_store
  import mbx_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int DEPTH = 4 * NQ,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  mbx_kind_e     kind,
  input  logic [1:0]    cls,
  input  logic [QW-1:0] qidx,
  input  logic [63:0]   wdata,
  output logic [63:0]   rdata
);
  logic [63:0] ctx_q [DEPTH];
  logic [63:0] tbl_q [2];
  logic [AW-1:0] idx;

  assign idx = AW'(cls) * AW'(NQ) + AW'(qidx);

  for (genvar g = 0; g < DEPTH; g++) begin : g_ctx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctx_q[g] <= '0;
      else if (we && kind == KIND_CTX && idx == AW'(g)) ctx_q[g] <= wdata;
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tbl_q[t] <= '0;
      else if (we && kind == KIND_TBL && cls[0] == 1'(t)) tbl_q[t] <= wdata;
    end
  end

  always_comb begin
    case (kind)
      KIND_CTX: rdata = ctx_q[idx];
      KIND_TBL: rdata = tbl_q[cls[0]];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_latency_timer.sv
module mbx_latency_timer #(
  parameter int LAT = 4,
  localparam int TW = $clog2(LAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (start)                  cnt_q <= TW'(LAT);
    else if (active && cnt_q != '0)  cnt_q <= cnt_q - TW'(1);
  end

  assign expire = active && (cnt_q == TW'(1));
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int NQ = 8,
  parameter int LAT = 4,
  parameter logic [9:0] QBASE = 10'd0,
  parameter int CW = 16,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel_hi,
  input  logic [63:0]   wr_data,
  output logic [63:0]   mb_lo,
  output logic [63:0]   mb_hi,
  output logic [CW-1:0] done_cnt
);
  logic [63:0]   lo_q, hi_q;
  logic [CW-1:0] cnt_q;
  logic          busy, launch, finish, host_wr, store_we, dir_fetch;
  mbx_kind_e     kind;
  mbx_res_e      res;
  logic [QW-1:0] qidx;
  logic [63:0]   store_rd, fetch_data;

  assign busy      = lo_q[BUSY_BIT];
  assign dir_fetch = lo_q[DIR_BIT];
  assign host_wr   = wr_en && !busy;
  assign launch    = host_wr && !wr_sel_hi && wr_data[BUSY_BIT];

  mbx_latency_timer #(.LAT(LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .active(busy), .expire(finish)
  );

  mbx_cmd_decode #(.NQ(NQ)) u_dec (
    .cmd(lo_q[3:0]), .dir_fetch(dir_fetch), .queue(lo_q[31:16]),
    .kind(kind), .res(res), .qidx(qidx)
  );

  assign store_we = finish && !dir_fetch && res == RES_OK;

  mbx_ctx_store #(.NQ(NQ)) u_store (
    .clk(clk), .rst_n(rst_n), .we(store_we), .kind(kind), .cls(lo_q[1:0]),
    .qidx(qidx), .wdata({hi_q[31:0], lo_q[63:32]}), .rdata(store_rd)
  );

  assign fetch_data = (kind == KIND_FUNC) ? func_word(QBASE, 11'(NQ)) : store_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
    end else if (finish) begin
      lo_q[BUSY_BIT]          <= 1'b0;
      lo_q[RES_LSB+3:RES_LSB] <= res;
      if (dir_fetch && res == RES_OK) begin
        lo_q[63:32] <= fetch_data[31:0];
        hi_q[31:0]  <= fetch_data[63:32];
      end
      cnt_q <= cnt_q + CW'(1);
    end else if (host_wr) begin
      if (wr_sel_hi) hi_q <= wr_data;
      else           lo_q <= wr_data;
    end
  end

  assign mb_lo    = lo_q;
  assign mb_hi    = hi_q;
  assign done_cnt = cnt_q;
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk #(
  parameter int LAT = 4,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_sel_hi,
  input logic [63:0]   mb_lo,
  input logic [63:0]   mb_hi,
  input logic [CW-1:0] done_cnt,
  input logic          launch,
  input logic          finish
);
  logic        busy;
  logic [31:0] held_q;
  assign busy = mb_lo[13];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held_q <= '0;
    else if (launch) held_q <= 32'd1;
    else if (busy)   held_q <= held_q + 32'd1;
  end

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> held_q == 32'(LAT));
  assert_start_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && !wr_sel_hi));
  assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mb_lo) && $stable(mb_hi)));
  assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_cnt == $past(done_cnt) + CW'(1));
  assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(done_cnt));
  assert_badcmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mb_lo[3:0] >= 4'd7) |-> mb_lo[12:9] == 4'd1);
endmodule

bind mbx_engine mbx_engine_chk #(.LAT(LAT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_hi(wr_sel_hi),
  .mb_lo(mb_lo), .mb_hi(mb_hi), .done_cnt(done_cnt),
  .launch(launch), .finish(finish)
);

// File: tb/tb_mbx_engine.sv
module tb_mbx_engine;
  localparam int NQ = 4;
  localparam int LAT = 3;
  localparam logic [9:0] QB = 10'd5;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_sel_hi = 0;
  logic [63:0] wr_data = '0;
  logic [63:0] mb_lo, mb_hi;
  logic [CW-1:0] done_cnt;
  int checks = 0, fails = 0, exp_cnt = 0;
  bit finished = 0;
  logic [63:0] ctx_m [4][NQ];
  logic [63:0] tbl_m [2];

  always #4 clk = ~clk;

  mbx_engine #(.NQ(NQ), .LAT(LAT), .QBASE(QB), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_hi(wr_sel_hi),
    .wr_data(wr_data), .mb_lo(mb_lo), .mb_hi(mb_hi), .done_cnt(done_cnt)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input bit hi, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic logic [15:0] ctrl(input logic [3:0] c, input bit f, input bit b, input logic [3:0] r);
    return {1'b0, f, b, r, 5'd0, c};
  endfunction

  // Issue one command, measure busy, check preserved fields and counter.
  task automatic run(input logic [3:0] c, input bit f, input logic [15:0] q,
                     input logic [63:0] base, input logic [31:0] tok,
                     output logic [3:0] res, output logic [63:0] rb);
    int n;
    put(1, {tok, base[63:32]});
    put(0, {base[31:0], q, ctrl(c, f, 1'b1, 4'd0)});
    n = 0;
    while (mb_lo[13] === 1'b1 && n < 100) begin n++; @(negedge clk); end
    chk("R3 busy cycles", 64'(n), 64'(LAT));
    exp_cnt++;
    chk("R11 counter", 64'(done_cnt), 64'(exp_cnt));
    chk("R12 ctrl kept", {48'd0, mb_lo[15:13], mb_lo[8:0]}, {48'd0, 1'b0, f, 1'b0, 5'd0, c});
    chk("R12 queue kept", 64'(mb_lo[31:16]), 64'(q));
    chk("R12 token kept", 64'(mb_hi[63:32]), 64'(tok));
    res = mb_lo[12:9];
    rb = {mb_hi[31:0], mb_lo[63:32]};
  endtask

  function automatic logic [63:0] pat(input int c, input int q);
    return 64'(c) * 64'h0100_0000_0001 + 64'(q) * 64'h0000_0101_0000_0100 + 64'h1234_0000_0000_0007;
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] r;
    logic [63:0] d;
    logic [63:0] fexp;
    int n;
    repeat (3) @(negedge clk);
    chk("R1 lo reset", mb_lo, 64'd0);
    chk("R1 hi reset", mb_hi, 64'd0);
    chk("R1 cnt reset", 64'(done_cnt), 64'd0);
    rst_n = 1;

    // R2: idle writes store, busy clear starts nothing
    put(1, 64'hAAAA_5555_0123_4567);
    put(0, 64'h89AB_CDEF_0002_0001);
    repeat (LAT + 2) @(negedge clk);
    chk("R2 hi stored", mb_hi, 64'hAAAA_5555_0123_4567);
    chk("R2 lo stored no launch", mb_lo, 64'h89AB_CDEF_0002_0001);
    chk("R2 cnt idle", 64'(done_cnt), 64'd0);

    // R6: unwritten entry reads zero
    run(4'd2, 1, 16'd1, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1, r, d);
    chk("R6 fresh res", 64'(r), 64'd0);
    chk("R6 fresh zero", d, 64'd0);

    // R5: store sweep
    for (int c = 0; c < 4; c++)
      for (int q = 0; q < NQ; q++) begin
        run(4'(c), 0, 16'(q), pat(c, q), 32'(c * 16 + q), r, d);
        ctx_m[c][q] = pat(c, q);
        chk("R5 store res", 64'(r), 64'd0);
        chk("R5 base kept", d, pat(c, q));
      end
    // R6: fetch sweep
    for (int c = 0; c < 4; c++)
      for (int q = 0; q < NQ; q++) begin
        run(4'(c), 1, 16'(q), 64'h0, 32'hBEEF, r, d);
        chk("R6 fetch res", 64'(r), 64'd0);
        chk("R6 fetch data", d, ctx_m[c][q]);
      end

    // R7: table bases, queue ignored
    run(4'd4, 0, 16'd999, 64'h0000_0040_0000_1000, 32'h0, r, d);
    tbl_m[0] = 64'h0000_0040_0000_1000;
    run(4'd5, 0, 16'd3, 64'h0000_0080_0000_2000, 32'h0, r, d);
    tbl_m[1] = 64'h0000_0080_0000_2000;
    chk("R7 store res", 64'(r), 64'd0);
    run(4'd4, 1, 16'd77, 64'h0, 32'h0, r, d);
    chk("R7 fetch tbl0", d, tbl_m[0]);
    run(4'd5, 1, 16'hFFFF, 64'h0, 32'h0, r, d);
    chk("R7 fetch tbl1", d, tbl_m[1]);
    chk("R7 fetch res", 64'(r), 64'd0);

    // R8: function-table query
    fexp = 64'(QB) * (64'd1 << 28) + (64'd1 << 44) + 64'(NQ - 1) * (64'd1 << 45);
    run(4'd6, 1, 16'd0, 64'h0, 32'h0, r, d);
    chk("R8 query res", 64'(r), 64'd0);
    chk("R8 query word", d, fexp);
    run(4'd6, 0, 16'd0, 64'h1111_2222_3333_4444, 32'h0, r, d);
    chk("R8 readonly res", 64'(r), 64'd3);
    chk("R8 readonly base kept", d, 64'h1111_2222_3333_4444);

    // R9: unsupported codes in both directions
    for (int c = 7; c < 16; c++)
      for (int f = 0; f < 2; f++) begin
        run(4'(c), f[0], 16'd0, 64'h5A5A_0000_0000_A5A5, 32'h0, r, d);
        chk("R9 badcmd res", 64'(r), 64'd1);
        chk("R9 base kept", d, 64'h5A5A_0000_0000_A5A5);
      end
    for (int c = 0; c < 4; c++) begin
      run(4'(c), 1, 16'd0, 64'h0, 32'h0, r, d);
      chk("R9 store untouched", d, ctx_m[c][0]);
    end

    // R10: queue out of range
    for (int c = 0; c < 4; c++) begin
      run(4'(c), 0, 16'(NQ), 64'hDEAD_0000_BEEF_0000, 32'h0, r, d);
      chk("R10 badq store res", 64'(r), 64'd2);
      run(4'(c), 1, 16'(NQ + c), 64'h0000_0000_0000_0042, 32'h0, r, d);
      chk("R10 badq fetch res", 64'(r), 64'd2);
      chk("R10 badq base kept", d, 64'h0000_0000_0000_0042);
      run(4'(c), 1, 16'(NQ - 1), 64'h0, 32'h0, r, d);
      chk("R10 top queue untouched", d, ctx_m[c][NQ - 1]);
    end

    // R4: writes during busy ignored
    put(1, {32'h7, 32'h0000_00C0});
    put(0, {32'h0000_0D00, 16'd1, ctrl(4'd1, 0, 1'b1, 4'd0)});
    @(negedge clk);
    wr_en = 1; wr_sel_hi = 1; wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    wr_sel_hi = 0; wr_data = {32'hEEEE_EEEE, 16'd2, ctrl(4'd0, 1, 1'b1, 4'd0)};
    @(negedge clk);
    wr_en = 0;
    n = 0;
    while (mb_lo[13] === 1'b1 && n < 100) begin n++; @(negedge clk); end
    exp_cnt++;
    chk("R4 no relaunch", 64'(n), 64'(LAT - 3));
    repeat (LAT + 2) @(negedge clk);
    chk("R4 single completion", 64'(done_cnt), 64'(exp_cnt));
    chk("R4 hi unchanged", mb_hi, {32'h7, 32'h0000_00C0});
    chk("R4 lo kept", mb_lo, {32'h0000_0D00, 16'd1, ctrl(4'd1, 0, 1'b0, 4'd0)});
    ctx_m[1][1] = 64'h0000_00C0_0000_0D00;
    run(4'd1, 1, 16'd1, 64'h0, 32'h0, r, d);
    chk("R4 stored value", d, ctx_m[1][1]);
    run(4'd0, 1, 16'd2, 64'h0, 32'h0, r, d);
    chk("R4 other entry", d, ctx_m[0][2]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule